// File: doc/BRIEF.md
# Pipelined Four-Lane Sorting Network

This block puts four unsigned values into ascending order. A set of four values is presented together with a single valid bit. The sorted set appears on the four output lanes, with the smallest value on lane 0, together with an output valid bit three clock edges later. A new set may be presented on every cycle, so the block sustains one sorted set per cycle with no stall and no backpressure.

The network has five compare-and-swap cells arranged in three registered stages. The first stage orders lane pairs (0,1) and (2,3). The second stage orders (0,2) and (1,3), which places the overall minimum on lane 0 and the overall maximum on lane 3. The third stage orders the two middle lanes (1,2). The valid bit travels beside the data through one flop per stage. Only the valid flops are reset. The data flops carry no reset, because no consumer samples them unless the valid bit that travels with them is set.

Top module: `sorter4_pipe`

## Requirements
- R1: While reset (`rst_n` low) is sampled, `out_valid` is low at the next edge. After reset, `out_valid` stays low until a valid input set has passed through all three stages.
- R2: A set sampled with `in_valid` high at a rising edge appears, with `out_valid` high, after the third rising edge that follows. `out_valid` is not high earlier than that.
- R3: When `out_valid` is high, the output lanes are in ascending order: lane 0 ≤ lane 1 ≤ lane 2 ≤ lane 3. For example, inputs 0x03, 0x09, 0x04, 0x01 give 0x01, 0x03, 0x04, 0x09.
- R4: The output set is a permutation of the input set. Repeated values keep their multiplicity.
- R5: Comparison is unsigned, so 0x80 and 0xFF sort above 0x7F.
- R6: Valid sets on consecutive cycles produce sorted sets on consecutive cycles, in the order they were accepted.
- R7: A cycle with `in_valid` low yields a cycle with `out_valid` low three edges later. Gaps in the input stream are reproduced at the output.
- R8: A reset applied while sets are in flight discards them. No `out_valid` follows from any set accepted before that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The input lanes carry a set to sort |
| in_lane0 | input | W | Input value, lane 0 |
| in_lane1 | input | W | Input value, lane 1 |
| in_lane2 | input | W | Input value, lane 2 |
| in_lane3 | input | W | Input value, lane 3 |
| out_valid | output | 1 | The output lanes carry a sorted set |
| out_lane0 | output | W | Smallest value |
| out_lane1 | output | W | Second value |
| out_lane2 | output | W | Third value |
| out_lane3 | output | W | Largest value |

## Verification
Every result of this block, both the sorted lanes and `out_valid`, is due exactly three rising edges after the edge that samples its input set. This holds equally for bubbles and for sets discarded by reset.

The bench drives inputs on falling edges and samples outputs on falling edges. At each falling edge it first compares the outputs against the set it drove three falling edges earlier, and only then drives the next set. A result that arrives one cycle early or one cycle late is therefore compared against the wrong entry and reported. The bench also checks `out_valid` low in the first three cycles after an idle start, which catches a result that arrives too early.

// File: rtl/sorter4_pkg.sv
// Shared constants for the four-lane sorting network.
// Assumes the lane count is fixed at four; only element width varies.
package sorter4_pkg;
    localparam int LANES  = 4;
    localparam int STAGES = 3;
    // Compare-swap schedule, one entry per stage: number of pairs, then
    // the low and high lane of the first and the second pair.
    localparam int ST_NPAIR [STAGES] = '{2, 2, 1};
    localparam int ST_LO_A  [STAGES] = '{0, 0, 1};
    localparam int ST_HI_A  [STAGES] = '{1, 2, 2};
    localparam int ST_LO_B  [STAGES] = '{2, 1, 0};
    localparam int ST_HI_B  [STAGES] = '{3, 3, 0};
endpackage

// File: rtl/sorter4_cmp_swap.sv
// Compare-and-swap cell: presents the unsigned smaller input on lo and the
// larger on hi. Purely combinational; assumes unsigned operands.
module sorter4_cmp_swap #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic a_gt_b;

    // select min and max from one unsigned comparison
    always_comb begin
        a_gt_b = (a > b);
        lo     = a_gt_b ? b : a;
        hi     = a_gt_b ? a : b;
    end
endmodule

// File: rtl/sorter4_stage.sv
// One registered stage of the network. It orders NPAIR lane pairs and
// passes the other lanes through unchanged. Assumes the pairs are disjoint.
// Only the valid flop is reset; the data flops are qualified by valid.
module sorter4_stage
    import sorter4_pkg::*;
#(
    parameter int W     = 8,
    parameter int NPAIR = 2,
    parameter int LO_A  = 0,
    parameter int HI_A  = 1,
    parameter int LO_B  = 2,
    parameter int HI_B  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic [LANES-1:0][W-1:0] data_i,
    output logic                  valid_o,
    output logic [LANES-1:0][W-1:0] data_o
);
    localparam int LO_IDX [2] = '{LO_A, LO_B};
    localparam int HI_IDX [2] = '{HI_A, HI_B};

    logic [W-1:0]             mn [NPAIR];
    logic [W-1:0]             mx [NPAIR];
    logic [LANES-1:0][W-1:0]  nxt;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        sorter4_cmp_swap #(.W(W)) u_cs (
            .a  (data_i[LO_IDX[p]]),
            .b  (data_i[HI_IDX[p]]),
            .lo (mn[p]),
            .hi (mx[p])
        );
    end

    // merge swapped pairs over the pass-through lanes
    always_comb begin
        nxt = data_i;
        for (int p = 0; p < NPAIR; p++) begin
            nxt[LO_IDX[p]] = mn[p];
            nxt[HI_IDX[p]] = mx[p];
        end
    end

    // valid flop with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // data flops, no reset needed
    always_ff @(posedge clk) begin
        data_o <= nxt;
    end

    AST_STAGE_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(valid_i))); // R2

    for (genvar p = 0; p < NPAIR; p++) begin : g_chk
        AST_PAIR_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> (data_o[LO_IDX[p]] <= data_o[HI_IDX[p]])); // R3
    end
endmodule

// File: rtl/sorter4_pipe.sv
// Four-lane ascending sorter: three registered compare-swap stages, one
// set accepted per cycle, fixed latency of three edges. Assumes the
// consumer never stalls. Comparison is unsigned.
module sorter4_pipe
    import sorter4_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_lane0,
    input  logic [W-1:0] in_lane1,
    input  logic [W-1:0] in_lane2,
    input  logic [W-1:0] in_lane3,
    output logic         out_valid,
    output logic [W-1:0] out_lane0,
    output logic [W-1:0] out_lane1,
    output logic [W-1:0] out_lane2,
    output logic [W-1:0] out_lane3
);
    localparam int SW = W + 2;

    logic [LANES-1:0][W-1:0] dchain [STAGES+1];
    logic                    vchain [STAGES+1];

    // gather the input lanes into the head of the chain
    always_comb begin
        vchain[0]    = in_valid;
        dchain[0][0] = in_lane0;
        dchain[0][1] = in_lane1;
        dchain[0][2] = in_lane2;
        dchain[0][3] = in_lane3;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        sorter4_stage #(
            .W     (W),
            .NPAIR (ST_NPAIR[s]),
            .LO_A  (ST_LO_A[s]),
            .HI_A  (ST_HI_A[s]),
            .LO_B  (ST_LO_B[s]),
            .HI_B  (ST_HI_B[s])
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (vchain[s]),
            .data_i  (dchain[s]),
            .valid_o (vchain[s+1]),
            .data_o  (dchain[s+1])
        );
    end

    // present the tail of the chain on the output ports
    always_comb begin
        out_valid = vchain[STAGES];
        out_lane0 = dchain[STAGES][0];
        out_lane1 = dchain[STAGES][1];
        out_lane2 = dchain[STAGES][2];
        out_lane3 = dchain[STAGES][3];
    end

    logic [SW-1:0] in_sum, out_sum;

    // lane sums for the permutation check
    always_comb begin
        in_sum  = SW'(in_lane0) + SW'(in_lane1) + SW'(in_lane2) + SW'(in_lane3);
        out_sum = SW'(out_lane0) + SW'(out_lane1) + SW'(out_lane2) + SW'(out_lane3);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1

    AST_OUT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lane0 <= out_lane1 && out_lane1 <= out_lane2
                       && out_lane2 <= out_lane3)); // R3

    AST_SUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum == $past(in_sum, 3))); // R4
endmodule

// File: tb/tb_sorter4_pipe.sv
`timescale 1ns/1ps
module tb_sorter4_pipe;
    localparam int W = 8;
    localparam int MAXN = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_lane0 = '0, in_lane1 = '0, in_lane2 = '0, in_lane3 = '0;
    logic         out_valid;
    logic [W-1:0] out_lane0, out_lane1, out_lane2, out_lane3;

    int tests_run = 0;
    int tests_failed = 0;

    logic [W-1:0] sv_data [MAXN][4];
    logic         sv_vld  [MAXN];

    always #2.5 clk = ~clk;

    sorter4_pipe #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_lane0(in_lane0), .in_lane1(in_lane1),
        .in_lane2(in_lane2), .in_lane3(in_lane3),
        .out_valid(out_valid),
        .out_lane0(out_lane0), .out_lane1(out_lane1),
        .out_lane2(out_lane2), .out_lane3(out_lane3)
    );

    function automatic logic [31:0] sorted_word(logic [W-1:0] a, logic [W-1:0] b,
                                                logic [W-1:0] c, logic [W-1:0] d);
        logic [W-1:0] v [4];
        logic [W-1:0] t;
        v[0] = a; v[1] = b; v[2] = c; v[3] = d;
        for (int i = 1; i < 4; i++) begin
            for (int j = i; j > 0; j--) begin
                if (v[j] < v[j-1]) begin
                    t = v[j]; v[j] = v[j-1]; v[j-1] = t;
                end
            end
        end
        return {v[3], v[2], v[1], v[0]};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_idx(int j, int n);
        if (j < n) begin
            in_valid = sv_vld[j];
            in_lane0 = sv_data[j][0]; in_lane1 = sv_data[j][1];
            in_lane2 = sv_data[j][2]; in_lane3 = sv_data[j][3];
        end else begin
            in_valid = 1'b0;
            in_lane0 = 8'hAA; in_lane1 = 8'h55; in_lane2 = 8'hAA; in_lane3 = 8'h55;
        end
    endtask

    // drive n entries one per cycle; check each result three cycles later
    task automatic run_stream(int n, string req);
        logic [31:0] exp;
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (i < 3) begin
                check(out_valid == 1'b0, "R2", {31'b0, out_valid}, 32'h0);
            end else begin
                int j = i - 3;
                if (sv_vld[j]) begin
                    exp = sorted_word(sv_data[j][0], sv_data[j][1], sv_data[j][2], sv_data[j][3]);
                    check(out_valid == 1'b1, "R2", {31'b0, out_valid}, 32'h1);
                    check({out_lane3, out_lane2, out_lane1, out_lane0} == exp, req,
                          {out_lane3, out_lane2, out_lane1, out_lane0}, exp);
                end else begin
                    check(out_valid == 1'b0, "R7", {31'b0, out_valid}, 32'h0);
                end
            end
            drive_idx(i, n);
        end
    endtask

    task automatic set_entry(int j, logic v, logic [W-1:0] a, logic [W-1:0] b,
                             logic [W-1:0] c, logic [W-1:0] d);
        sv_vld[j] = v;
        sv_data[j][0] = a; sv_data[j][1] = b; sv_data[j][2] = c; sv_data[j][3] = d;
    endtask

    task automatic t_reset();
        in_valid = 1'b1;
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", {31'b0, out_valid}, 32'h0);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", {31'b0, out_valid}, 32'h0);
        end
    endtask

    task automatic t_example();
        set_entry(0, 1'b1, 8'h03, 8'h09, 8'h04, 8'h01);
        run_stream(1, "R3");
    endtask

    task automatic t_unsigned();
        set_entry(0, 1'b1, 8'hFF, 8'h80, 8'h7F, 8'h00);
        run_stream(1, "R5");
        set_entry(0, 1'b1, 8'h81, 8'h01, 8'hFE, 8'h7F);
        run_stream(1, "R5");
    endtask

    task automatic t_duplicates();
        set_entry(0, 1'b1, 8'h55, 8'h55, 8'h12, 8'h55);
        run_stream(1, "R4");
        set_entry(0, 1'b1, 8'h09, 8'h09, 8'h09, 8'h09);
        run_stream(1, "R4");
    endtask

    task automatic t_back_to_back();
        for (int j = 0; j < 8; j++) begin
            set_entry(j, 1'b1, 8'(j * 37 + 5), 8'(200 - j * 11), 8'(j * j + 3), 8'(j * 91));
        end
        run_stream(8, "R6");
    endtask

    task automatic t_bubbles();
        set_entry(0, 1'b1, 8'h10, 8'h23, 8'h02, 8'h41);
        set_entry(1, 1'b0, 8'h01, 8'h02, 8'h03, 8'h04);
        set_entry(2, 1'b1, 8'h02, 8'h55, 8'h13, 8'h07);
        set_entry(3, 1'b1, 8'hC0, 8'h0C, 8'h30, 8'h03);
        set_entry(4, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        set_entry(5, 1'b1, 8'h40, 8'h30, 8'h20, 8'h10);
        run_stream(6, "R7");
    endtask

    task automatic t_midreset();
        @(negedge clk);
        in_valid = 1'b1; in_lane0 = 8'h04; in_lane1 = 8'h03; in_lane2 = 8'h02; in_lane3 = 8'h01;
        @(negedge clk);
        in_lane0 = 8'h14;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) begin
            check(out_valid == 1'b0, "R8", {31'b0, out_valid}, 32'h0);
            @(negedge clk);
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_example();
                t_unsigned();
                t_duplicates();
                t_back_to_back();
                t_bubbles();
                t_midreset();
            end
            begin
                repeat (100000) @(posedge clk);
                tests_run++;
                tests_failed++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule